// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer. A prescale counter below the timer supplies two fractional bits, so the timer and those bits together form a 10-bit time base. The duty setting is compared against this 10-bit value. The duty setting therefore has four times the resolution of the period setting, measured in timer steps.

Software may change the period and duty inputs at any moment. The duty value only takes effect at a period boundary. At each rollover it is copied into a shadow compare register, so a write made in the middle of a period can never cut a pulse short or stretch it. At every rollover the block raises a one-cycle period tick. Dropping the enable input stops the timer and forces the output low at once.

Top module: `pwm10_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `pwm_out` and `period_tick` are both 0.
- R2: While enabled, `period_tick` pulses once every (period+1)*4*S clock cycles. S is the prescale factor chosen by `psel`: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 give 16.
- R3: At each rollover, `period_tick` is high for exactly one cycle. In that same cycle the `duty` value present at the rollover becomes the shadow duty, and `pwm_out` goes high if that shadow duty is nonzero.
- R4: For a shadow duty D with 0 < D < (period+1)*4, `pwm_out` is high for D*S cycles, counted from the tick cycle, and then low for the rest of the period.
- R5: A shadow duty of 0 keeps `pwm_out` low for the whole period, including the tick cycle.
- R6: A shadow duty of (period+1)*4 or more keeps `pwm_out` high for the whole period.
- R7: A change of `duty` after a rollover has no effect on the output until the next rollover.
- R8: When `en` is 0, the timer and shadow duty clear and `pwm_out` is 0 from the next cycle. After `en` returns to 1, `pwm_out` stays low until the first tick, which comes (period+1)*4*S cycles later.
- R9: `pwm_out` only rises in a cycle in which `period_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable; 0 clears all state |
| psel | input | 2 | Prescale select: 00 = 1, 01 = 4, 1x = 16 |
| period | input | 8 | Period value in timer steps, minus one |
| duty | input | 10 | Requested duty in quarter timer steps |
| pwm_out | output | 1 | PWM output |
| period_tick | output | 1 | One-cycle pulse at each rollover |

## Verification
The bench sweeps several periods, every prescale code and a set of duties. The duties include 0, 1, 2, half scale, one below full scale, exactly full scale, and above full scale. The period length and the high-cycle count are computed arithmetically.

A design that compares the current time base instead of the next one would give one cycle too many of high time. A design that set the output on a zero duty would show a one-cycle glitch. A design that treated full scale as an ordinary compare would drop low for a prescale step. To catch a design that copies duty continuously, the duty is changed right after each tick and the period that follows is checked against the new value only. Each run starts from a disable, so the bench also sees an output left high by the disable, or a first period that starts early.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam int FRAC_W = 2;
    localparam int PRE_W  = FRAC_W + 4;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV4   = 2'b01,
        PS_DIV16  = 2'b10,
        PS_DIV16B = 2'b11
    } prescale_e;

    // last prescale count before the timer advances
    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
        case (prescale_e'(sel))
            PS_DIV1: return PRE_W'(3);
            PS_DIV4: return PRE_W'(15);
            default: return PRE_W'(63);
        endcase
    endfunction

    // fractional bits of the time base taken from the prescale count
    function automatic logic [FRAC_W-1:0] sub_of(input logic [1:0] sel,
                                                  input logic [PRE_W-1:0] frac);
        case (prescale_e'(sel))
            PS_DIV1: return frac[1:0];
            PS_DIV4: return frac[3:2];
            default: return frac[5:4];
        endcase
    endfunction

endpackage

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8,
    localparam int TB_W = TMR_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       psel,
    input  logic [TMR_W-1:0] period,
    output logic             rollover,
    output logic [TB_W-1:0]  tb_next
);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [PRE_W-1:0] frac;
    } tb_state_t;

    tb_state_t        st_q, st_d;
    logic [PRE_W-1:0] limit;
    logic             step;

    always_comb begin
        limit    = pre_limit(psel);
        step     = (st_q.frac >= limit);
        st_d     = st_q;
        rollover = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (step) begin
            st_d.frac = '0;
            if (st_q.tmr == period) begin
                st_d.tmr = '0;
                rollover = 1'b1;
            end else begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
        end else begin
            st_d.frac = st_q.frac + 1'b1;
        end
        tb_next = {st_d.tmr, sub_of(psel, st_d.frac)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_rollover_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> (st_q.tmr == '0) && (st_q.frac == '0));

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q == '0));

    assert_timer_holds_between_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> $stable(st_q.tmr));

endmodule

// File: rtl/pwm10_compare.sv
module pwm10_compare #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rollover,
    input  logic [DW-1:0] tb_next,
    input  logic [DW-1:0] duty,
    output logic          pwm,
    output logic          tick
);

    typedef struct packed {
        logic          out;
        logic          tick;
        logic [DW-1:0] shadow;
    } cmp_state_t;

    cmp_state_t cs_q, cs_d;

    always_comb begin
        cs_d      = cs_q;
        cs_d.tick = rollover;
        if (!en) begin
            cs_d = '0;
        end else if (rollover) begin
            cs_d.shadow = duty;
            cs_d.out    = (duty != '0);
        end else if (tb_next == cs_q.shadow) begin
            cs_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign pwm  = cs_q.out;
    assign tick = cs_q.tick;

    assert_set_follows_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.tick |-> (cs_q.out == (cs_q.shadow != '0)));

    assert_rise_only_at_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_q.out) |-> cs_q.tick);

    assert_shadow_loads_at_rollover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rollover) |=> (cs_q.shadow == $past(duty)));

    assert_tick_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.tick |=> !cs_q.tick);

    assert_disable_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!cs_q.out && !cs_q.tick));

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8,
    localparam int DW = TMR_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       psel,
    input  logic [TMR_W-1:0] period,
    input  logic [DW-1:0]    duty,
    output logic             pwm_out,
    output logic             period_tick
);

    logic          rollover;
    logic [DW-1:0] tb_next;

    pwm10_timebase #(.TMR_W(TMR_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .psel     (psel),
        .period   (period),
        .rollover (rollover),
        .tb_next  (tb_next)
    );

    pwm10_compare #(.DW(DW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rollover (rollover),
        .tb_next  (tb_next),
        .duty     (duty),
        .pwm      (pwm_out),
        .tick     (period_tick)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) $rose(rst_n) |-> (!pwm_out && !period_tick));

endmodule

// File: tb/sim_pwm10_gen.sv
module sim_pwm10_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] psel = 2'b00;
    logic [7:0] period = 8'd0;
    logic [9:0] duty = 10'd0;
    logic       pwm_out;
    logic       period_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pwm10_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .psel        (psel),
        .period      (period),
        .duty        (duty),
        .pwm_out     (pwm_out),
        .period_tick (period_tick)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // measure one period starting at a tick sample; return cycle and high counts
    task automatic measure(input int limit, output int cnt, output int hi, output int rises);
        logic prev;
        cnt = 0; hi = 0; rises = 0;
        prev = pwm_out;
        do begin
            if (pwm_out) hi++;
            @(negedge clk);
            cnt++;
            if (pwm_out && !prev && !period_tick) rises++;
            prev = pwm_out;
        end while (!period_tick && cnt < limit);
    endtask

    task automatic run_case(input int p, input int sel, input int d);
        int ps, span, len, d2, n, highs, cnt, hi, rises, exp_hi;
        ps   = (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
        span = (p + 1) * 4;
        len  = span * ps;
        d2   = (d >= span) ? 0 : span - d;

        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 output low while disabled", int'(pwm_out), 0);

        period = 8'(p);
        psel   = 2'(sel);
        duty   = 10'(d);
        en     = 1'b1;
        n = 0; highs = 0;
        do begin
            @(negedge clk);
            n++;
            if (pwm_out && !period_tick) highs++;
        end while (!period_tick && n < len + 8);
        check("R8 first tick delay after enable", n, len);
        check("R8 output low before first tick", highs, 0);
        check("R3 output set at tick iff duty nonzero", int'(pwm_out), (d != 0) ? 1 : 0);

        // R7: the new duty written right after the tick must not affect this period
        duty = 10'(d2);
        measure(len + 8, cnt, hi, rises);
        exp_hi = ((d < span) ? d : span) * ps;
        check("R2 period length", cnt, len);
        if (d == 0)         check("R5 zero duty high count", hi, 0);
        else if (d >= span) check("R6 full duty high count", hi, exp_hi);
        else                check("R4 high count (R7 old duty kept)", hi, exp_hi);
        check("R9 no rise outside tick", rises, 0);

        measure(len + 8, cnt, hi, rises);
        check("R2 second period length", cnt, len);
        check("R7 new duty applied after rollover", hi, d2 * ps);
        check("R9 no rise outside tick second period", rises, 0);
    endtask

    initial begin
        int plist[4];
        int dl[7];
        int span;
        plist = '{0, 1, 4, 9};
        repeat (3) @(negedge clk);
        check("R1 output low in reset", int'(pwm_out), 0);
        check("R1 tick low in reset", int'(period_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 output low after reset", int'(pwm_out), 0);
        check("R1 tick low after reset", int'(period_tick), 0);

        foreach (plist[i]) begin
            span = (plist[i] + 1) * 4;
            dl = '{0, 1, 2, span / 2, span - 1, span, span + 3};
            for (int sel = 0; sel < 4; sel++) begin
                foreach (dl[k]) run_case(plist[i], sel, dl[k]);
            end
        end
        // widest period, largest duty code that still produces a compare
        run_case(255, 0, 1023);
        run_case(255, 0, 512);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule